// File: doc/BRIEF.md
# AHB Bus Transfer Trace Recorder

This block watches an AHB bus without driving it. Each transfer it accepts is written as one 128-bit record into a 64-slot circular store. A record holds a 32-bit time tag, a breakpoint flag, the control signals of the address phase, the address, and the data word of the matching data phase. The data word is the write data for writes and the read data for reads.

Software controls the block through simple strobe inputs. These set or clear the record enable and load the slot pointer. Any slot can be read back as four 32-bit words. An external breakpoint matcher signals a hit together with the address phase. The flagged record is written, recording stops by itself, and a one-cycle interrupt pulse is raised.

The time tag is a free-running counter. It can be held while the processors are halted in debug mode. When the debug bus enable input is low, the whole block is gated off.

Top module: `ahb_trace_recorder`

## Requirements
- R1: After reset `trace_en` is 0, `trace_idx` is 0, `irq` is 0 and `rd_data` is 0.
- R2: A transfer is accepted in a cycle with `htrans` NONSEQ (2'b10) or SEQ (2'b11) and `hready` high. Its record is written on the next later clock edge at which `hready` is high. IDLE (2'b00), BUSY (2'b01), and cycles with `hready` low start no record. Accepted transfers may be pipelined back to back.
- R3: Record layout, MSB first:
  - tag [127:96]
  - breakpoint flag [95]
  - `hirq[15:1]` [94:80]
  - `hwrite` [79]
  - `htrans` [78:77]
  - `hsize` [76:74]
  - `hburst` [73:71]
  - `hmaster` [70:67]
  - `hmastlock` [66]
  - `hresp` [65:64]
  - data [63:32]
  - `haddr` [31:0]

  `hresp` and the data word come from the data phase; all other bus fields come from the address phase. The data word is `hwdata` when `hwrite`=1 and `hrdata` otherwise.
- R4: Each record is written to slot `trace_idx`, which then advances by one and wraps from 63 to 0.
- R5: Transfers are accepted only while the enable is set. A `sw_en_we` pulse loads the enable from `sw_en_val`. While the enable is clear, no record is written and the index holds.
- R6: A `sw_idx_we` pulse loads the index from `sw_idx_val`, and the next record goes to that slot. If the load falls in the same cycle as a record write, the record goes to the old slot and the loaded value wins over the increment.
- R7: `brk_hit` is sampled with the accepted address phase. That record has bit 95 set. The enable is cleared at the edge that writes it, and `irq` is high for exactly the following cycle. A transfer accepted in the same cycle is dropped. The hardware clear wins over a software set in that cycle.
- R8: The time tag resets to 0 and increments once per cycle while `dsu_tmr_en` or `cpu_upcnt_en` is high. A record holds the counter value from the cycle in which it is written.
- R9: The counter holds while `frz_in_dbg`=1, `cpu_in_dbg`=1 and `keep_run`=0. It runs when `frz_in_dbg`=0 or `keep_run`=1.
- R10: While `dbg_bus_en` is low:
  - no record is written and the counter holds;
  - software strobes are ignored;
  - `trace_en`, `trace_idx`, `irq` and `rd_data` read 0.

  Stored state is kept.
- R11: `rd_data` returns word `rd_sel` of slot `rd_idx` one cycle after the select is applied. Word 0 is bits 31:0 (address) and word 3 is bits 127:96 (tag).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_bus_en | input | 1 | Debug bus enable; low gates the block off |
| htrans | input | 2 | Monitored transfer type |
| hready | input | 1 | Monitored ready |
| hwrite | input | 1 | Monitored direction |
| hsize | input | 3 | Monitored size |
| hburst | input | 3 | Monitored burst type |
| hmaster | input | 4 | Monitored master number |
| hmastlock | input | 1 | Monitored locked transfer |
| hresp | input | 2 | Monitored response |
| haddr | input | 32 | Monitored address |
| hwdata | input | 32 | Monitored write data |
| hrdata | input | 32 | Monitored read data |
| hirq | input | 16 | Monitored interrupt lines |
| brk_hit | input | 1 | Breakpoint match for the current address phase |
| dsu_tmr_en | input | 1 | Debug timer enable |
| cpu_upcnt_en | input | 1 | Any processor up-counter enable |
| cpu_in_dbg | input | 1 | Processors halted in debug mode |
| frz_in_dbg | input | 1 | Hold the time tag while in debug mode |
| keep_run | input | 1 | Keep the time tag running regardless |
| sw_en_we | input | 1 | Strobe to load the enable |
| sw_en_val | input | 1 | Enable value to load |
| sw_idx_we | input | 1 | Strobe to load the index |
| sw_idx_val | input | IDX_W (6) | Index value to load |
| rd_idx | input | IDX_W (6) | Slot to read |
| rd_sel | input | 2 | Word within the slot to read |
| rd_data | output | 32 | Read word, one cycle latency |
| trace_en | output | 1 | Current enable |
| trace_idx | output | IDX_W (6) | Next slot to write |
| irq | output | 1 | Breakpoint interrupt pulse |

## Verification
A record write and a software load of the slot pointer can land in the same cycle. The bench provokes this by pulsing the index load during the data phase of a transfer. The record must then appear in the old slot, and the next record must appear at the loaded slot. A breakpoint record write can also coincide with a software enable set and with the next pipelined address phase; the bench requires the enable to read 0, the index to advance by one only, and `irq` to pulse once.

// File: rtl/trc_pkg.sv
package trc_pkg;

  localparam int WORD_W  = 32;
  localparam int ENTRY_W = 128;
  localparam int NWORDS  = ENTRY_W / WORD_W;
  localparam int SEL_W   = $clog2(NWORDS);

  localparam logic [1:0] TR_IDLE = 2'b00;
  localparam logic [1:0] TR_BUSY = 2'b01;

  // address-phase snapshot
  typedef struct packed {
    logic        brk;
    logic [14:0] irq;
    logic        write;
    logic [1:0]  trans;
    logic [2:0]  size;
    logic [2:0]  burst;
    logic [3:0]  master;
    logic        lock;
    logic [31:0] addr;
  } trc_aph_t;

  // stored record, MSB first
  typedef struct packed {
    logic [31:0] tag;
    logic        brk;
    logic [14:0] irq;
    logic        write;
    logic [1:0]  trans;
    logic [2:0]  size;
    logic [2:0]  burst;
    logic [3:0]  master;
    logic        lock;
    logic [1:0]  resp;
    logic [31:0] data;
    logic [31:0] addr;
  } trc_entry_t;

endpackage

// File: rtl/trc_timetag.sv
module trc_timetag #(
  parameter int TAG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_en,
  input  logic             dsu_tmr_en,
  input  logic             cpu_upcnt_en,
  input  logic             cpu_in_dbg,
  input  logic             frz_in_dbg,
  input  logic             keep_run,
  output logic [TAG_W-1:0] tag_q
);

  logic             run_src;
  logic             frozen;
  logic             tick;
  logic [TAG_W-1:0] tag_d;

  always_comb begin
    run_src = dsu_tmr_en | cpu_upcnt_en;
    frozen  = frz_in_dbg & cpu_in_dbg & ~keep_run;
    tick    = gate_en & run_src & ~frozen;
    tag_d   = tag_q + {{(TAG_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
    end else if (tick) begin
      tag_q <= tag_d;
    end
  end

endmodule

// File: rtl/trc_capture.sv
module trc_capture
  import trc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        gate_en,
  input  logic        trace_en_q,
  input  logic [1:0]  htrans,
  input  logic        hready,
  input  logic        hwrite,
  input  logic [2:0]  hsize,
  input  logic [2:0]  hburst,
  input  logic [3:0]  hmaster,
  input  logic        hmastlock,
  input  logic [1:0]  hresp,
  input  logic [31:0] haddr,
  input  logic [31:0] hwdata,
  input  logic [31:0] hrdata,
  input  logic [15:0] hirq,
  input  logic        brk_hit,
  input  logic [31:0] tag_q,
  output logic        ent_wr,
  output logic        ent_brk,
  output trc_entry_t  ent
);

  logic     pend_q, pend_d;
  trc_aph_t aph_q, aph_d;
  trc_aph_t aph_now;
  logic     active_tr;
  logic     accept;
  logic     irq0_unused;

  assign irq0_unused = hirq[0];

  always_comb begin
    active_tr = (htrans != TR_IDLE) && (htrans != TR_BUSY);
    // a pending breakpoint record closes the trace: nothing more is taken
    accept    = gate_en & trace_en_q & ~(pend_q & aph_q.brk) & active_tr & hready;
    ent_wr    = gate_en & pend_q & hready;
    ent_brk   = aph_q.brk;

    aph_now = '{brk:    brk_hit,
                irq:    hirq[15:1],
                write:  hwrite,
                trans:  htrans,
                size:   hsize,
                burst:  hburst,
                master: hmaster,
                lock:   hmastlock,
                addr:   haddr};

    aph_d = accept ? aph_now : aph_q;

    if (!gate_en)    pend_d = 1'b0;
    else if (accept) pend_d = 1'b1;
    else if (ent_wr) pend_d = 1'b0;
    else             pend_d = pend_q;

    ent = '{tag:    tag_q,
            brk:    aph_q.brk,
            irq:    aph_q.irq,
            write:  aph_q.write,
            trans:  aph_q.trans,
            size:   aph_q.size,
            burst:  aph_q.burst,
            master: aph_q.master,
            lock:   aph_q.lock,
            resp:   hresp,
            data:   aph_q.write ? hwdata : hrdata,
            addr:   aph_q.addr};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      aph_q  <= '0;
    end else begin
      pend_q <= pend_d;
      aph_q  <= aph_d;
    end
  end

endmodule

// File: rtl/trc_ctrl.sv
module trc_ctrl #(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_en,
  input  logic             sw_en_we,
  input  logic             sw_en_val,
  input  logic             sw_idx_we,
  input  logic [IDX_W-1:0] sw_idx_val,
  input  logic             ent_wr,
  input  logic             ent_brk,
  output logic             en_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             irq_q
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic             en_d;
  logic [IDX_W-1:0] idx_d;
  logic [IDX_W-1:0] idx_inc;
  logic             irq_d;
  logic             brk_wr;

  always_comb begin
    brk_wr  = gate_en & ent_wr & ent_brk;
    idx_inc = (idx_q == LAST) ? '0 : idx_q + 1'b1;

    // hardware stop wins over a software set
    if (brk_wr)                   en_d = 1'b0;
    else if (gate_en && sw_en_we) en_d = sw_en_val;
    else                          en_d = en_q;

    // software load wins over the increment
    if (gate_en && sw_idx_we)   idx_d = sw_idx_val;
    else if (gate_en && ent_wr) idx_d = idx_inc;
    else                        idx_d = idx_q;

    irq_d = brk_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      idx_q <= '0;
      irq_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      idx_q <= idx_d;
      irq_q <= irq_d;
    end
  end

endmodule

// File: rtl/trc_store.sv
module trc_store
  import trc_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gate_en,
  input  logic               wr,
  input  logic [IDX_W-1:0]   wr_idx,
  input  trc_entry_t         wr_ent,
  input  logic [IDX_W-1:0]   rd_idx,
  input  logic [SEL_W-1:0]   rd_sel,
  output logic [WORD_W-1:0]  rd_q
);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0]  words [NWORDS];
  logic [WORD_W-1:0]  rd_d;

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    assign words[g] = mem[rd_idx][g*WORD_W +: WORD_W];
  end

  always_comb begin
    rd_d = gate_en ? words[rd_sel] : '0;
  end

  // storage array: no reset, written with a clock enable
  always_ff @(posedge clk) begin
    if (wr) begin
      mem[wr_idx] <= wr_ent;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

endmodule

// File: rtl/ahb_trace_recorder.sv
module ahb_trace_recorder
  import trc_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbg_bus_en,
  input  logic [1:0]       htrans,
  input  logic             hready,
  input  logic             hwrite,
  input  logic [2:0]       hsize,
  input  logic [2:0]       hburst,
  input  logic [3:0]       hmaster,
  input  logic             hmastlock,
  input  logic [1:0]       hresp,
  input  logic [31:0]      haddr,
  input  logic [31:0]      hwdata,
  input  logic [31:0]      hrdata,
  input  logic [15:0]      hirq,
  input  logic             brk_hit,
  input  logic             dsu_tmr_en,
  input  logic             cpu_upcnt_en,
  input  logic             cpu_in_dbg,
  input  logic             frz_in_dbg,
  input  logic             keep_run,
  input  logic             sw_en_we,
  input  logic             sw_en_val,
  input  logic             sw_idx_we,
  input  logic [IDX_W-1:0] sw_idx_val,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [1:0]       rd_sel,
  output logic [31:0]      rd_data,
  output logic             trace_en,
  output logic [IDX_W-1:0] trace_idx,
  output logic             irq
);

  logic [31:0]      tag_q;
  logic             en_q;
  logic [IDX_W-1:0] idx_q;
  logic             irq_q;
  logic             ent_wr;
  logic             ent_brk;
  trc_entry_t       ent;

  trc_timetag #(.TAG_W(32)) u_tag (
    .clk          (clk),
    .rst_n        (rst_n),
    .gate_en      (dbg_bus_en),
    .dsu_tmr_en   (dsu_tmr_en),
    .cpu_upcnt_en (cpu_upcnt_en),
    .cpu_in_dbg   (cpu_in_dbg),
    .frz_in_dbg   (frz_in_dbg),
    .keep_run     (keep_run),
    .tag_q        (tag_q)
  );

  trc_capture u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_en    (dbg_bus_en),
    .trace_en_q (en_q),
    .htrans     (htrans),
    .hready     (hready),
    .hwrite     (hwrite),
    .hsize      (hsize),
    .hburst     (hburst),
    .hmaster    (hmaster),
    .hmastlock  (hmastlock),
    .hresp      (hresp),
    .haddr      (haddr),
    .hwdata     (hwdata),
    .hrdata     (hrdata),
    .hirq       (hirq),
    .brk_hit    (brk_hit),
    .tag_q      (tag_q),
    .ent_wr     (ent_wr),
    .ent_brk    (ent_brk),
    .ent        (ent)
  );

  trc_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_en    (dbg_bus_en),
    .sw_en_we   (sw_en_we),
    .sw_en_val  (sw_en_val),
    .sw_idx_we  (sw_idx_we),
    .sw_idx_val (sw_idx_val),
    .ent_wr     (ent_wr),
    .ent_brk    (ent_brk),
    .en_q       (en_q),
    .idx_q      (idx_q),
    .irq_q      (irq_q)
  );

  trc_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .gate_en (dbg_bus_en),
    .wr      (ent_wr),
    .wr_idx  (idx_q),
    .wr_ent  (ent),
    .rd_idx  (rd_idx),
    .rd_sel  (rd_sel),
    .rd_q    (rd_data)
  );

  always_comb begin
    trace_en  = dbg_bus_en & en_q;
    trace_idx = dbg_bus_en ? idx_q : '0;
    irq       = dbg_bus_en & irq_q;
  end

endmodule

// File: rtl/trc_chk.sv
module trc_chk #(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dbg_bus_en,
  input logic             cpu_in_dbg,
  input logic             frz_in_dbg,
  input logic             keep_run,
  input logic             sw_idx_we,
  input logic             ent_wr,
  input logic [IDX_W-1:0] idx_q,
  input logic [31:0]      tag_q,
  input logic             trace_en,
  input logic             irq
);

  logic [IDX_W-1:0] idx_next;
  always_comb idx_next = (idx_q == IDX_W'(DEPTH - 1)) ? '0 : idx_q + 1'b1;

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_bus_en && ent_wr && !sw_idx_we) |=> (idx_q == $past(idx_next)));

  // R10
  no_rec_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_bus_en |-> !ent_wr);

  // R10
  tag_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_bus_en |=> $stable(tag_q));

  // R7
  brk_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !trace_en);

  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R9
  tag_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_in_dbg && cpu_in_dbg && !keep_run) |=> $stable(tag_q));

endmodule

bind ahb_trace_recorder trc_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dbg_bus_en (dbg_bus_en),
  .cpu_in_dbg (cpu_in_dbg),
  .frz_in_dbg (frz_in_dbg),
  .keep_run   (keep_run),
  .sw_idx_we  (sw_idx_we),
  .ent_wr     (ent_wr),
  .idx_q      (idx_q),
  .tag_q      (tag_q),
  .trace_en   (trace_en),
  .irq        (irq)
);

// File: tb/ahb_trace_recorder_tb_top.sv
module ahb_trace_recorder_tb_top;

  logic        clk;
  logic        rst_n;
  logic        dbg_bus_en;
  logic [1:0]  htrans;
  logic        hready, hwrite, hmastlock;
  logic [2:0]  hsize, hburst;
  logic [3:0]  hmaster;
  logic [1:0]  hresp;
  logic [31:0] haddr, hwdata, hrdata;
  logic [15:0] hirq;
  logic        brk_hit, dsu_tmr_en, cpu_upcnt_en, cpu_in_dbg, frz_in_dbg, keep_run;
  logic        sw_en_we, sw_en_val, sw_idx_we;
  logic [5:0]  sw_idx_val, rd_idx;
  logic [1:0]  rd_sel;
  logic [31:0] rd_data;
  logic        trace_en;
  logic [5:0]  trace_idx;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mdl_tag;

  ahb_trace_recorder dut_i (
    .clk(clk), .rst_n(rst_n), .dbg_bus_en(dbg_bus_en),
    .htrans(htrans), .hready(hready), .hwrite(hwrite), .hsize(hsize),
    .hburst(hburst), .hmaster(hmaster), .hmastlock(hmastlock), .hresp(hresp),
    .haddr(haddr), .hwdata(hwdata), .hrdata(hrdata), .hirq(hirq),
    .brk_hit(brk_hit), .dsu_tmr_en(dsu_tmr_en), .cpu_upcnt_en(cpu_upcnt_en),
    .cpu_in_dbg(cpu_in_dbg), .frz_in_dbg(frz_in_dbg), .keep_run(keep_run),
    .sw_en_we(sw_en_we), .sw_en_val(sw_en_val), .sw_idx_we(sw_idx_we),
    .sw_idx_val(sw_idx_val), .rd_idx(rd_idx), .rd_sel(rd_sel),
    .rd_data(rd_data), .trace_en(trace_en), .trace_idx(trace_idx), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // independent time-tag model built from R8, R9, R10
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mdl_tag <= 32'd0;
    else if (dbg_bus_en && (dsu_tmr_en || cpu_upcnt_en) &&
             !(frz_in_dbg && cpu_in_dbg && !keep_run))
      mdl_tag <= mdl_tag + 32'd1;
  end

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [31:0] rd;
    logic [2:0]  size;
    logic [2:0]  burst;
    logic [3:0]  mst;
    logic        lock;
    logic [15:0] irqv;
    logic [31:0] exp_data;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 32'h4000_0010, 32'hDEAD_BEEF, 32'h1111_1111, 3'd2, 3'd0, 4'd3,  1'b0, 16'h8002, 32'hDEAD_BEEF},
    '{1'b0, 32'h8000_0004, 32'h2222_2222, 32'hCAFE_F00D, 3'd2, 3'd1, 4'd0,  1'b1, 16'h0001, 32'hCAFE_F00D},
    '{1'b1, 32'hFFFF_FFFC, 32'h0000_00A5, 32'h0000_0000, 3'd0, 3'd3, 4'd15, 1'b0, 16'hFFFF, 32'h0000_00A5},
    '{1'b0, 32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 3'd1, 3'd7, 4'd9,  1'b1, 16'h5554, 32'h1234_5678},
    '{1'b1, 32'h0000_1000, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 3'd3, 3'd2, 4'd1,  1'b0, 16'h0000, 32'h0F0F_0F0F},
    '{1'b0, 32'hA0A0_A0A0, 32'h3333_3333, 32'h00C0_FFEE, 3'd2, 3'd5, 4'd6,  1'b0, 16'h0100, 32'h00C0_FFEE}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_ent(input logic [31:0] tag, input logic brk,
      input vec_t v, input logic [1:0] trans, input logic [1:0] resp);
    return {tag, brk, v.irqv[15:1], v.wr, trans, v.size, v.burst, v.mst, v.lock,
            resp, v.exp_data, v.addr};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_aph(input vec_t v, input logic [1:0] trans, input logic brk);
    htrans = trans; hwrite = v.wr; haddr = v.addr; hsize = v.size; hburst = v.burst;
    hmaster = v.mst; hmastlock = v.lock; hirq = v.irqv; brk_hit = brk;
  endtask

  task automatic drive_idle();
    htrans = 2'b00; brk_hit = 1'b0; hwrite = 1'b0; haddr = '0; hirq = '0;
  endtask

  // single transfer; optional index load during the data phase
  task automatic do_xfer(input vec_t v, input logic poke, input logic [5:0] pval,
                         output logic [31:0] tag_e);
    @(negedge clk);
    drive_aph(v, 2'b10, 1'b0); hready = 1'b1;
    @(negedge clk);
    drive_idle(); hwdata = v.wd; hrdata = v.rd; hresp = 2'b00;
    sw_idx_we = poke; sw_idx_val = pval;
    tag_e = mdl_tag;
    @(negedge clk);
    hwdata = '0; hrdata = '0; sw_idx_we = 1'b0;
  endtask

  task automatic rd_word(input logic [5:0] idx, input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk); rd_idx = idx; rd_sel = sel;
    @(negedge clk); d = rd_data;
  endtask

  task automatic chk_ent(input string req, input logic [5:0] idx, input logic [127:0] exp);
    logic [31:0] d;
    for (int s = 0; s < 4; s++) begin
      rd_word(idx, 2'(s), d);
      chk(req, d, exp[s*32 +: 32]);
    end
  endtask

  task automatic sw_en(input logic val);
    @(negedge clk); sw_en_we = 1'b1; sw_en_val = val;
    @(negedge clk); sw_en_we = 1'b0;
  endtask

  task automatic sw_idx(input logic [5:0] val);
    @(negedge clk); sw_idx_we = 1'b1; sw_idx_val = val;
    @(negedge clk); sw_idx_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] t1, t2, d;
    rst_n = 1'b0; dbg_bus_en = 1'b1; htrans = 2'b00; hready = 1'b1; hwrite = 1'b0;
    hsize = '0; hburst = '0; hmaster = '0; hmastlock = 1'b0; hresp = '0;
    haddr = '0; hwdata = '0; hrdata = '0; hirq = '0; brk_hit = 1'b0;
    dsu_tmr_en = 1'b1; cpu_upcnt_en = 1'b0; cpu_in_dbg = 1'b0; frz_in_dbg = 1'b0;
    keep_run = 1'b0; sw_en_we = 1'b0; sw_en_val = 1'b0; sw_idx_we = 1'b0;
    sw_idx_val = '0; rd_idx = '0; rd_sel = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    chk("R1 trace_en", {31'd0, trace_en}, 32'd0);
    chk("R1 trace_idx", {26'd0, trace_idx}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 rd_data", rd_data, 32'd0);

    // R5 enable
    sw_en(1'b1);
    chk("R5 enable set", {31'd0, trace_en}, 32'd1);

    // table walk: R2 R3 R4 R11
    for (int i = 0; i < 6; i++) begin
      do_xfer(VECS[i], 1'b0, 6'd0, t1);
      chk("R4 index step", {26'd0, trace_idx}, 32'(i + 1));
      chk_ent("R3 R11 record", 6'(i), mk_ent(t1, 1'b0, VECS[i], 2'b10, 2'b00));
    end

    // R2 pipelined pair with a wait state
    @(negedge clk);
    drive_aph(VECS[0], 2'b10, 1'b0); hready = 1'b1;
    @(negedge clk);
    drive_aph(VECS[1], 2'b11, 1'b0); hready = 1'b0; hwdata = VECS[0].wd; hresp = 2'b01;
    @(negedge clk);
    hready = 1'b1; hresp = 2'b00; t1 = mdl_tag;
    @(negedge clk);
    drive_idle(); hrdata = VECS[1].rd; hresp = 2'b10; t2 = mdl_tag;
    @(negedge clk);
    hrdata = '0; hwdata = '0; hresp = 2'b00;
    chk("R2 pipelined index", {26'd0, trace_idx}, 32'd8);
    chk_ent("R2 stalled record", 6'd6, mk_ent(t1, 1'b0, VECS[0], 2'b10, 2'b00));
    chk_ent("R2 SEQ record", 6'd7, mk_ent(t2, 1'b0, VECS[1], 2'b11, 2'b10));

    // R2 IDLE, BUSY and hready-low address phases start nothing
    @(negedge clk); drive_aph(VECS[2], 2'b01, 1'b0); hready = 1'b1;
    @(negedge clk); drive_aph(VECS[2], 2'b10, 1'b0); hready = 1'b0;
    @(negedge clk); drive_idle(); hready = 1'b1;
    cyc(2);
    chk("R2 no record for idle/busy/stall", {26'd0, trace_idx}, 32'd8);

    // R5 disabled: nothing recorded
    sw_en(1'b0);
    chk("R5 enable cleared", {31'd0, trace_en}, 32'd0);
    do_xfer(VECS[3], 1'b0, 6'd0, t1);
    cyc(1);
    chk("R5 index holds while disabled", {26'd0, trace_idx}, 32'd8);
    sw_en(1'b1);

    // R6 index load then R4 wrap
    sw_idx(6'd62);
    chk("R6 index loaded", {26'd0, trace_idx}, 32'd62);
    do_xfer(VECS[0], 1'b0, 6'd0, t1);
    do_xfer(VECS[1], 1'b0, 6'd0, t2);
    do_xfer(VECS[2], 1'b0, 6'd0, d);
    chk("R4 wrap index", {26'd0, trace_idx}, 32'd1);
    chk_ent("R6 record at loaded slot", 6'd62, mk_ent(t1, 1'b0, VECS[0], 2'b10, 2'b00));
    chk_ent("R4 record at slot 63", 6'd63, mk_ent(t2, 1'b0, VECS[1], 2'b10, 2'b00));
    chk_ent("R4 record after wrap", 6'd0, mk_ent(d, 1'b0, VECS[2], 2'b10, 2'b00));

    // R6 index load in the same cycle as a record write
    do_xfer(VECS[3], 1'b1, 6'd40, t1);
    chk("R6 load wins over increment", {26'd0, trace_idx}, 32'd40);
    chk_ent("R6 concurrent record in old slot", 6'd1, mk_ent(t1, 1'b0, VECS[3], 2'b10, 2'b00));
    do_xfer(VECS[4], 1'b0, 6'd0, t2);
    chk("R6 next index", {26'd0, trace_idx}, 32'd41);
    chk_ent("R6 next record at loaded slot", 6'd40, mk_ent(t2, 1'b0, VECS[4], 2'b10, 2'b00));

    // R7 breakpoint with pipelined follower and concurrent software set
    @(negedge clk);
    drive_aph(VECS[5], 2'b10, 1'b1); hready = 1'b1;
    @(negedge clk);
    drive_aph(VECS[0], 2'b10, 1'b0); hrdata = VECS[5].rd; t1 = mdl_tag;
    sw_en_we = 1'b1; sw_en_val = 1'b1;
    @(negedge clk);
    sw_en_we = 1'b0; drive_idle(); hrdata = '0; hwdata = VECS[0].wd;
    chk("R7 irq pulse high", {31'd0, irq}, 32'd1);
    chk("R7 enable cleared by hardware", {31'd0, trace_en}, 32'd0);
    chk("R7 index advanced once", {26'd0, trace_idx}, 32'd42);
    @(negedge clk);
    hwdata = '0;
    chk("R7 irq single cycle", {31'd0, irq}, 32'd0);
    chk("R7 follower dropped", {26'd0, trace_idx}, 32'd42);
    chk_ent("R7 flagged record", 6'd41, mk_ent(t1, 1'b1, VECS[5], 2'b10, 2'b00));
    sw_en(1'b1);

    // R8 timer off: tag holds
    dsu_tmr_en = 1'b0;
    do_xfer(VECS[0], 1'b0, 6'd0, t1);
    cyc(5);
    do_xfer(VECS[1], 1'b0, 6'd0, t2);
    chk("R8 tag held with timer off", t2, t1);
    chk_ent("R8 tag value timer off", 6'd43, mk_ent(t2, 1'b0, VECS[1], 2'b10, 2'b00));

    // R8 up-counter source alone runs the tag
    cpu_upcnt_en = 1'b1;
    do_xfer(VECS[2], 1'b0, 6'd0, t1);
    chk_ent("R8 tag from up-counter", 6'd44, mk_ent(t1, 1'b0, VECS[2], 2'b10, 2'b00));

    // R9 freeze in debug mode
    cpu_in_dbg = 1'b1; frz_in_dbg = 1'b1; keep_run = 1'b0;
    cyc(1);
    do_xfer(VECS[3], 1'b0, 6'd0, t1);
    cyc(4);
    do_xfer(VECS[4], 1'b0, 6'd0, t2);
    chk("R9 tag frozen in debug", t2, t1);
    chk_ent("R9 frozen tag record", 6'd46, mk_ent(t2, 1'b0, VECS[4], 2'b10, 2'b00));
    keep_run = 1'b1;
    do_xfer(VECS[5], 1'b0, 6'd0, t2);
    chk("R9 override runs tag", {31'd0, (t2 != t1)}, 32'd1);
    chk_ent("R9 override tag record", 6'd47, mk_ent(t2, 1'b0, VECS[5], 2'b10, 2'b00));
    cpu_in_dbg = 1'b0; frz_in_dbg = 1'b0; keep_run = 1'b0;

    // R10 gated off
    @(negedge clk); dbg_bus_en = 1'b0;
    cyc(1);
    chk("R10 trace_en gated", {31'd0, trace_en}, 32'd0);
    chk("R10 trace_idx gated", {26'd0, trace_idx}, 32'd0);
    rd_word(6'd47, 2'd0, d);
    chk("R10 rd_data gated", d, 32'd0);
    do_xfer(VECS[0], 1'b0, 6'd0, t1);
    sw_idx(6'd5);
    sw_en(1'b0);
    @(negedge clk); dbg_bus_en = 1'b1;
    cyc(1);
    chk("R10 enable kept", {31'd0, trace_en}, 32'd1);
    chk("R10 index kept", {26'd0, trace_idx}, 32'd48);
    do_xfer(VECS[1], 1'b0, 6'd0, t2);
    chk_ent("R10 R8 record after gating", 6'd48, mk_ent(t2, 1'b0, VECS[1], 2'b10, 2'b00));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule